// File: doc/BRIEF.md
# Cascadable Serial-In Latched Channel Driver

This block turns a slow serial bit stream into ten parallel channel levels, as needed to drive display segments or print-head dots. A serial data line is shifted into a ten-stage register, one bit per rising edge of an external shift clock. A level-sensitive load input copies that register into an output holding store. While the load input is low, the channel pattern stays fixed and the next word can be shifted in behind it. An active-high blank input drives every channel low without disturbing the stored pattern.

The final register stage is brought out as a serial output. Several copies can therefore be chained into one long shift path. All four control inputs are asynchronous to the fast system clock, which samples each of them through a two-flop synchroniser. A checker watches the synchronised shift clock and load input. It raises a one-cycle flag when a clock high time, a load high time, or the gap from a clock rise to a load rise is shorter than a parameterised number of system cycles. The serial stream is a plain wire paced by the shift clock, not a valid/ready stream, so there is no back-pressure.

Top module: `serial_latch_driver`

## Requirements
- R1: A synchronous active-high reset clears the shift register and the holding store. After reset `chan_o` is all zero, and `ser_out_o` and `timing_err_o` are 0.
- R2: Each detected rising edge of the synchronised `ser_clk_i` loads the synchronised `ser_data_i` into stage 1 (bit 0) and moves every stage i into stage i+1. Without such an edge the register does not change.
- R3: `ser_out_o` always shows stage 10 (bit 9). After a shift it carries the value that stage 9 held before that shift. A second device fed from it therefore receives the first ten bits of a 20-bit load.
- R4: While the synchronised `load_i` is high, the holding store takes the shift register contents every system cycle, so the channels follow the shifts.
- R5: While the synchronised `load_i` is low, the holding store keeps its value however the shift register changes.
- R6: While the synchronised `blank_i` is high, `chan_o` is all zero. While it is low, `chan_o[i]` equals bit i of the holding store, where bit i holds stage i+1. Releasing blank restores the held pattern without a reload.
- R7: Bits shifted in with the most significant bit first leave word bit i on `chan_o[i]` after ten shifts and one load pulse.
- R8: If the synchronised shift clock stays high for fewer than `MIN_CLK_HIGH` cycles, `timing_err_o` pulses for one cycle after the clock falls.
- R9: If the synchronised load input stays high for fewer than `MIN_LOAD_HIGH` cycles, `timing_err_o` pulses for one cycle after it falls.
- R10: If the synchronised load input rises fewer than `MIN_CLK_TO_LOAD` cycles after the most recent shift clock rise, `timing_err_o` pulses for one cycle. A same-cycle rise also counts as a violation. Inputs that respect all three minima raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous shift clock; shifts on its rising edge |
| ser_data_i | input | 1 | Asynchronous serial data into stage 1 |
| load_i | input | 1 | Asynchronous level-sensitive load of the holding store |
| blank_i | input | 1 | Asynchronous active-high blank of all channels |
| ser_out_o | output | 1 | Last shift stage, used for chaining |
| chan_o | output | CHANNELS | Channel levels after the blank gate |
| timing_err_o | output | 1 | One-cycle flag for an input timing violation |

## Verification
The assertions assume that the serial data is steady in the synchroniser cycles around each detected clock rise. They also assume reset is held through the first clock edge, so the stage and store relations only apply once reset has been seen. The stimulus drives every input on the falling system clock edge. It holds data for two cycles before each shift-clock rise and keeps clock and load pulses longer than the minima, except in the deliberate violation tests. In the chained pair the downstream device samples the upstream tail two cycles late, which those long pulses keep inside a single shift.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b,
                                            input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return $clog2(m + 1) + 1;
  endfunction

  typedef struct packed {
    logic blank;
    logic load;
    logic data;
    logic sclk;
  } ctl_t;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = sld_pkg::SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= async_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sld_edge.sv
module sld_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign rise_o[i] = lvl_i[i] & ~prev_q[i];
      assign fall_o[i] = ~lvl_i[i] & prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/sld_shift.sv
module sld_shift #(
  parameter int unsigned DEPTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [DEPTH-1:0] stages_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)         sr_q <= '0;
    else if (step_i) sr_q <= {sr_q[DEPTH-2:0], bit_i};
  end

  assign stages_o = sr_q;

  a_r2_no_step_holds: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(sr_q));
  a_r3_tail_takes_prev: assert property (@(posedge clk) disable iff (rst)
    step_i |=> sr_q[DEPTH-1] == $past(sr_q[DEPTH-2]));
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> sr_q == '0);
endmodule

// File: rtl/sld_hold.sv
module sld_hold #(
  parameter int unsigned DEPTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             blank_i,
  input  logic [DEPTH-1:0] src_i,
  output logic [DEPTH-1:0] chan_o
);
  logic [DEPTH-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst)         store_q <= '0;
    else if (load_i) store_q <= src_i;
  end

  assign chan_o = blank_i ? '0 : store_q;

  a_r4_follows: assert property (@(posedge clk) disable iff (rst)
    load_i |=> store_q == $past(src_i));
  a_r5_keeps: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(store_q));
  a_r6_blanked_low: assert property (@(posedge clk) disable iff (rst)
    blank_i |-> chan_o == '0);
endmodule

// File: rtl/sld_timing.sv
module sld_timing #(
  parameter int unsigned MIN_CLK_HIGH    = 5,
  parameter int unsigned MIN_LOAD_HIGH   = 5,
  parameter int unsigned MIN_CLK_TO_LOAD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_lvl_i,
  input  logic sclk_rise_i,
  input  logic sclk_fall_i,
  input  logic load_lvl_i,
  input  logic load_rise_i,
  input  logic load_fall_i,
  output logic err_o
);
  localparam int unsigned CW = sld_pkg::cnt_width(MIN_CLK_HIGH, MIN_LOAD_HIGH, MIN_CLK_TO_LOAD);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] clk_hi_q, load_hi_q, gap_q;
  logic          viol, err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_hi_q  <= '0;
      load_hi_q <= '0;
      gap_q     <= CMAX;
      err_q     <= 1'b0;
    end else begin
      if (sclk_rise_i)                        clk_hi_q <= CW'(1);
      else if (sclk_lvl_i && clk_hi_q != CMAX) clk_hi_q <= clk_hi_q + 1'b1;

      if (load_rise_i)                        load_hi_q <= CW'(1);
      else if (load_lvl_i && load_hi_q != CMAX) load_hi_q <= load_hi_q + 1'b1;

      if (sclk_rise_i)        gap_q <= CW'(1);
      else if (gap_q != CMAX) gap_q <= gap_q + 1'b1;

      err_q <= viol;
    end
  end

  always_comb begin
    viol = 1'b0;
    if (sclk_fall_i && clk_hi_q < CW'(MIN_CLK_HIGH))  viol = 1'b1;
    if (load_fall_i && load_hi_q < CW'(MIN_LOAD_HIGH)) viol = 1'b1;
    if (load_rise_i && (sclk_rise_i || gap_q < CW'(MIN_CLK_TO_LOAD))) viol = 1'b1;
  end

  assign err_o = err_q;

  a_r8_short_clock_flagged: assert property (@(posedge clk) disable iff (rst)
    (sclk_fall_i && clk_hi_q < CW'(MIN_CLK_HIGH)) |=> err_o);
  a_r10_same_cycle_flagged: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise_i && load_rise_i) |=> err_o);
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
  parameter int unsigned CHANNELS        = 10,
  parameter int unsigned MIN_CLK_HIGH    = 5,
  parameter int unsigned MIN_LOAD_HIGH   = 5,
  parameter int unsigned MIN_CLK_TO_LOAD = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk_i,
  input  logic                ser_data_i,
  input  logic                load_i,
  input  logic                blank_i,
  output logic                ser_out_o,
  output logic [CHANNELS-1:0] chan_o,
  output logic                timing_err_o
);
  import sld_pkg::*;

  localparam int unsigned CTL_W = $bits(ctl_t);

  ctl_t             raw, syn;
  logic [CTL_W-1:0] syn_bits;
  logic [1:0]       lvl, rise, fall;
  logic [CHANNELS-1:0] stages;

  always_comb begin
    raw.blank = blank_i;
    raw.load  = load_i;
    raw.data  = ser_data_i;
    raw.sclk  = ser_clk_i;
  end

  sld_sync #(.WIDTH(CTL_W)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw), .sync_o(syn_bits)
  );
  assign syn = ctl_t'(syn_bits);
  assign lvl = {syn.load, syn.sclk};

  sld_edge #(.WIDTH(2)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(lvl), .rise_o(rise), .fall_o(fall)
  );

  sld_shift #(.DEPTH(CHANNELS)) u_shift (
    .clk(clk), .rst(rst), .step_i(rise[0]), .bit_i(syn.data), .stages_o(stages)
  );

  sld_hold #(.DEPTH(CHANNELS)) u_hold (
    .clk(clk), .rst(rst), .load_i(syn.load), .blank_i(syn.blank),
    .src_i(stages), .chan_o(chan_o)
  );

  sld_timing #(
    .MIN_CLK_HIGH(MIN_CLK_HIGH), .MIN_LOAD_HIGH(MIN_LOAD_HIGH),
    .MIN_CLK_TO_LOAD(MIN_CLK_TO_LOAD)
  ) u_timing (
    .clk(clk), .rst(rst),
    .sclk_lvl_i(syn.sclk), .sclk_rise_i(rise[0]), .sclk_fall_i(fall[0]),
    .load_lvl_i(syn.load), .load_rise_i(rise[1]), .load_fall_i(fall[1]),
    .err_o(timing_err_o)
  );

  assign ser_out_o = stages[CHANNELS-1];

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (chan_o == '0 && !ser_out_o && !timing_err_o));
endmodule

// File: tb/serial_latch_driver_test.sv
module serial_latch_driver_test;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, load = 1'b0, blank = 1'b0;
  logic ser_a, ser_b, err_a, err_b;
  logic [N-1:0] chan_a, chan_b;
  int checks = 0, fails = 0, err_pulses = 0;

  always #10 clk = ~clk;

  serial_latch_driver uut (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_data_i(sdata), .load_i(load),
    .blank_i(blank), .ser_out_o(ser_a), .chan_o(chan_a), .timing_err_o(err_a)
  );
  serial_latch_driver link (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_data_i(ser_a), .load_i(load),
    .blank_i(blank), .ser_out_o(ser_b), .chan_o(chan_b), .timing_err_o(err_b)
  );

  always @(negedge clk) if (!rst && err_a) err_pulses++;

  // {blank, word}
  localparam logic [N:0] VEC [6] = '{
    {1'b0, 10'h2A5}, {1'b0, 10'h3FF}, {1'b1, 10'h155},
    {1'b0, 10'h001}, {1'b0, 10'h200}, {1'b0, 10'h0F0}
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b, input int hi);
    sdata = b; idle(2);
    sclk = 1'b1; idle(hi);
    sclk = 1'b0; idle(4);
  endtask

  task automatic shift_word(input logic [N-1:0] w);
    for (int i = N-1; i >= 0; i--) shift_bit(w[i], 6);
  endtask

  task automatic pulse_load(input int hi);
    load = 1'b1; idle(hi);
    load = 1'b0; idle(4);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] prev;
    idle(3);
    // R1: reset state
    check("R1 chan", chan_a, '0);
    check("R1 serout/err", {8'd0, ser_a, err_a}, '0);
    rst = 1'b0; idle(2);

    // R2 R3 R6 R7: vector walk through a two-device chain
    prev = '0;
    foreach (VEC[k]) begin
      blank = VEC[k][N];
      shift_word(VEC[k][N-1:0]);
      pulse_load(6);
      idle(4);
      check("R7 R2 word on channels", chan_a, VEC[k][N] ? '0 : VEC[k][N-1:0]);
      check("R3 serial tail", {9'd0, ser_a}, {9'd0, VEC[k][N-1]});
      check("R3 chained device", chan_b, VEC[k][N] ? '0 : prev);
      prev = VEC[k][N-1:0];
    end
    check("R10 no flag under legal timing", err_pulses, 0);

    // R5: load low keeps channels while new word shifts
    blank = 1'b0;
    shift_word(10'h0C3); pulse_load(6); idle(3);
    shift_word(10'h33C); idle(3);
    check("R5 held while shifting", chan_a, 10'h0C3);

    // R4: load high makes the store follow each shift
    load = 1'b1; idle(4);
    check("R4 transparent", chan_a, 10'h33C);
    shift_bit(1'b1, 6); idle(2);
    check("R4 follows shift", chan_a, 10'h279);
    load = 1'b0; idle(4);

    // R6: blank then release restores without reload
    blank = 1'b1; idle(4);
    check("R6 blanked", chan_a, '0);
    blank = 1'b0; idle(4);
    check("R6 restored", chan_a, 10'h279);

    // R8: short shift clock high
    err_pulses = 0;
    shift_bit(1'b0, 2); idle(4);
    check("R8 short clock flagged", err_pulses, 1);

    // R9: short load high
    err_pulses = 0;
    pulse_load(2); idle(4);
    check("R9 short load flagged", err_pulses, 1);

    // R10: load rises one cycle after clock rise
    err_pulses = 0;
    sclk = 1'b1; idle(1);
    load = 1'b1; idle(8);
    sclk = 1'b0; load = 1'b0; idle(6);
    check("R10 early load flagged", err_pulses, 1);

    // R1: reset mid-run clears everything
    rst = 1'b1; idle(3);
    check("R1 reset clears chan", chan_a, '0);
    rst = 1'b0; idle(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule